// File: doc/BRIEF.md
# Serial PLL Bit-Stream Loader

This block pushes a 56-bit programming word for an external clock synthesizer through a one-bit-wide control port, one register write per bit. The word arrives as seven bytes. Byte i sits on `word_in[8i+7:8i]`. When `start` is pulsed while the block is idle, the word and the inter-strobe gap are captured. The block then issues one write strobe per bit.

Each write value carries the data bit in bit 0 and a hold flag in bit 1. The hold flag is set only on the final write, so the synthesizer latches the new setting without a separate latch cycle. A programmable number of idle cycles separates strobes, which lets a slow serial port sample each bit. `busy` covers the frame, and `done` pulses once when the frame is over.

Top module: `pll_serial_loader`

## Requirements
- R1: Synchronous active-high `rst` leaves `busy`, `done` and `wr_stb` low from the cycle after it is sampled, and `wr_stb` stays low until a new start is accepted.
- R2: A `start` sampled while idle raises `busy` in the next cycle, and the first strobe appears in that same cycle.
- R3: Every frame contains exactly 56 strobes.
- R4: Bytes are sent in ascending index order: byte 0 (`word_in[7:0]`) first and byte 6 (`word_in[55:48]`) last.
- R5: Within each byte, bit 7 is sent first and bit 0 last.
- R6: On a strobe, `wr_val[0]` equals the data bit being sent. While no strobe is active, `wr_val` is 2'b00.
- R7: `wr_val[1]` (the hold flag) is 0 on strobes 1 to 55 and 1 on strobe 56.
- R8: Consecutive strobes are separated by exactly G idle cycles, where G is `gap` sampled at start, or 1 when that value is 0. Changes to `gap` during a frame have no effect.
- R9: A `start` while `busy` is ignored. The frame in progress keeps its word, its bit count and its timing.
- R10: `done` is high for exactly one cycle, the cycle right after strobe 56. `busy` is already low in that cycle, and a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send a frame (taken only while idle) |
| word_in | input | 56 | Programming word, byte i on bits 8i+7..8i |
| gap | input | 8 | Idle cycles between strobes (0 means 1) |
| wr_stb | output | 1 | One-cycle write strobe per bit |
| wr_val | output | 2 | Write value: bit 0 data, bit 1 hold flag |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
A wrong bit index inside the block shows up at once as a misordered or shifted data bit on `wr_val[0]`. A wrong index also moves the hold flag away from strobe 56, and the frame then ends early or late, which makes `done` arrive on the wrong cycle. A corrupted gap counter changes the spacing of the very next strobe. A busy flag stuck high or low shows up within one frame, either as a missing `done` pulse or as a second start that restarts the stream.

// File: rtl/pll_serial_loader.sv
module pll_serial_loader #(
  parameter int NBYTES = 7,
  parameter int GAPW   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NBYTES*8-1:0]   word_in,
  input  logic [GAPW-1:0]       gap,
  output logic                  wr_stb,
  output logic [1:0]            wr_val,
  output logic                  busy,
  output logic                  done
);
  localparam int NBITS = NBYTES * 8;
  localparam int IDXW  = $clog2(NBITS);

  logic [NBITS-1:0] word_q;
  logic [IDXW-1:0]  idx;
  logic [GAPW-1:0]  gap_q;
  logic [GAPW-1:0]  wait_q;
  logic             last;
  logic [IDXW-1:0]  sel;

  // byte = idx[IDXW-1:3], bit within byte counts down from 7
  assign sel    = {idx[IDXW-1:3], ~idx[2:0]};
  assign last   = (idx == IDXW'(NBITS - 1));
  assign wr_stb = busy && (wait_q == '0);
  assign wr_val = wr_stb ? {last, word_q[sel]} : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      wait_q <= '0;
      gap_q  <= '0;
      word_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          word_q <= word_in;
          gap_q  <= (gap == '0) ? GAPW'(1) : gap;
          idx    <= '0;
          wait_q <= '0;
        end
      end else if (wr_stb) begin
        wait_q <= gap_q;
        idx    <= idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_serial_loader_chk.sv
module pll_serial_loader_chk #(
  parameter int NBYTES = 7,
  parameter int GAPW   = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       wr_stb,
  input logic [1:0] wr_val,
  input logic       busy,
  input logic       done
);
  localparam int NBITS = NBYTES * 8;
  localparam int CW    = $clog2(NBITS) + 1;

  logic [CW-1:0] nstb;
  always_ff @(posedge clk) begin
    if (rst || done) nstb <= '0;
    else if (wr_stb) nstb <= nstb + 1'b1;
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !wr_stb && !done));
  // R7
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_val[1]) |-> (nstb == CW'(NBITS - 1)));
  // R3
  count_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && nstb == CW'(NBITS - 1)) |-> wr_val[1]);
  // R8
  gap_chk: assert property (@(posedge clk) disable iff (rst) wr_stb |=> !wr_stb);
  // R10
  done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_val[1]) |=> (done && !busy));
  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_stb && start) |=> busy);
  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb) |-> (wr_val == 2'b00));
endmodule

bind pll_serial_loader pll_serial_loader_chk #(.NBYTES(NBYTES), .GAPW(GAPW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .wr_stb(wr_stb),
  .wr_val(wr_val), .busy(busy), .done(done)
);

// File: tb/pll_serial_loader_bench.sv
module pll_serial_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [55:0] WORDS [NV] = '{56'h0123456789ABCD, 56'h8001FF005AA57E,
                                          56'h00000000000001, 56'hFFFFFFFFFFFF80};
  localparam logic [7:0]  GAPS  [NV] = '{8'd1, 8'd0, 8'd3, 8'd255};
  localparam bit          INJ   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst = 1, start = 0;
  logic [55:0] word_in = '0;
  logic [7:0] gap = '0;
  logic wr_stb, busy, done;
  logic [1:0] wr_val;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_serial_loader u_pll_serial_loader (
    .clk(clk), .rst(rst), .start(start), .word_in(word_in), .gap(gap),
    .wr_stb(wr_stb), .wr_val(wr_val), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [55:0] w, input logic [7:0] g, input bit inj);
    int nst = 0, t = 0, last_t = 0, bad_bit = -1, bad_hold = -1, bad_gap = -1;
    int first_t = -1, done_t = -1, eff, done_cnt = 0;
    bit busy_at_done = 1;
    eff = (g == 0) ? 1 : int'(g);
    @(negedge clk);
    start = 1; word_in = w; gap = g;
    @(negedge clk);
    start = 0; word_in = ~w; gap = 8'd7;
    t = 1;
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    while (t < 20000) begin
      if (wr_stb === 1'b1) begin
        if (nst < 56) begin
          if (wr_val[0] !== w[8*(nst/8) + 7 - (nst%8)] && bad_bit < 0) bad_bit = nst;
          if (wr_val[1] !== (nst == 55) && bad_hold < 0) bad_hold = nst;
        end
        if (nst == 0) first_t = t;
        else if (t - last_t != eff + 1 && bad_gap < 0) bad_gap = t - last_t;
        last_t = t;
        nst++;
        if (inj && nst == 10) start = 1;
      end else begin
        start = 0;
      end
      if (done === 1'b1) begin
        if (done_cnt == 0) begin done_t = t; busy_at_done = busy; end
        done_cnt++;
      end
      if (done_t >= 0 && t > done_t + 2) break;
      @(negedge clk);
      t++;
    end
    start = 0;
    chk(first_t == 1, "R2", "first strobe cycle", first_t, 1);
    chk(nst == 56, "R3", "strobe count", nst, 56);
    // R4 R5 R6: bit k comes from byte k/8, bit 7-k%8
    chk(bad_bit < 0, "R4/R5/R6", "first wrong data bit index", bad_bit, -1);
    chk(bad_hold < 0, "R7", "first wrong hold flag index", bad_hold, -1);
    chk(bad_gap < 0, "R8", "strobe spacing", bad_gap, eff + 1);
    chk(done_t == last_t + 1, "R10", "done cycle", done_t, last_t + 1);
    chk(done_cnt == 1, "R10", "done pulse length", done_cnt, 1);
    chk(busy_at_done == 1'b0, "R10", "busy during done", busy_at_done, 0);
    if (inj) chk(nst == 56 && bad_bit < 0, "R9", "start while busy ignored", nst, 56);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(busy === 0 && done === 0 && wr_stb === 0, "R1", "idle after reset",
        {busy, done, wr_stb}, 0);
    for (int i = 0; i < NV; i++) run_frame(WORDS[i], GAPS[i], INJ[i]);

    // R10: start exactly in the done cycle is accepted
    @(negedge clk);
    start = 1; word_in = 56'h55; gap = 8'd0;
    @(negedge clk);
    start = 0;
    while (done !== 1'b1) @(negedge clk);
    start = 1; word_in = 56'hA0; gap = 8'd0;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1 && wr_stb === 1'b1 && wr_val === 2'b01, "R10",
        "start in done cycle accepted", {busy, wr_stb, wr_val}, 4'b1101);

    // R1: reset in mid-frame
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(busy === 0 && wr_stb === 0 && done === 0, "R1", "idle after mid-frame reset",
        {busy, wr_stb, done}, 0);
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (wr_stb !== 1'b0) seen++; end
      chk(seen == 0, "R1", "no strobe after reset", seen, 0);
    end
    run_frame(56'hC3_96_3C_69_A5_5A_0F, 8'd2, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule